// File: doc/BRIEF.md
# GCM Phase-Controlled GHASH Engine

This block is the authentication half of a GCM or GMAC datapath, reached through a small word-wide register bus. Software moves it through a sequence of phases: init, header, payload and final. It writes 128-bit blocks as four 32-bit words to a data-input register. Each completed block is folded into a running GHASH accumulator Y by a bit-serial multiplier over GF(2^128). When the fold finishes, a completion flag is raised. The 128-bit result is read back as four 32-bit words from a data-output register.

The block does not contain a cipher. The hash subkey H and the encrypted pre-counter block arrive on input ports. In the final phase, the engine hashes a length block that software writes (header bit-length in the upper 64 bits, payload bit-length in the lower 64 bits). The output is then the tag, Y xor the pre-counter input. A GMAC run uses header blocks followed directly by the final phase.

Four suspend registers expose Y. Software can save a message part-way through, run another message, and later resume by writing the saved state back while the engine is disabled.

Top module: `gcm_ghash_engine`

## Requirements
- R1: After reset, every register is zero. `irq` is low. Reads of control (address 0), status (address 1) and the suspend words (addresses 4 to 7) return 0.
- R2: Blocks are assembled from four writes to address 2, and the first word written is bits 127:96 of the block. The fourth accepted write starts the update Y = (Y xor X)·H. The multiply uses the GCM bit order and the polynomial x^128+x^7+x^2+x+1. The completion flag (status bit 0) becomes set on the 128th rising edge after the edge that accepted the fourth word.
- R3: Four reads of address 3 return the result with the most significant word first. Outside the final phase, the result is Y.
- R4: The status flag is set only by a completed update. `irq` is high while the flag is set and the interrupt enable (control bit 4) is 1. Writing control with bit 3 = 1 clears both the flag and the error bit. When a clear write and a completion fall on the same edge, the flag ends up set.
- R5: Writing control with the enable bit (bit 0) = 1 and phase (bits 2:1) = 00 (init) clears Y to zero.
- R6: With phase 11 (final), address-3 reads return Y xor `tag_mask`. Software can move from header (01) to final (11) while the engine stays enabled.
- R7: A control write that moves the phase from init to payload (10) or to final (11) leaves the engine disabled, whatever value is written to bit 0. A later control write with bit 0 = 1 enables the engine.
- R8: Some data-input writes are ignored and set the error bit (status bit 1). This happens when the engine is disabled, in the init phase, while the flag is set, or while the multiply is busy (status bit 2). An ignored write does not count as a block word.
- R9: Clearing the enable bit during a multiply stops it. Busy drops, Y keeps its old value, the flag is not set, and any partly assembled block is discarded.
- R10: Addresses 4 to 7 read Y, with address 4 returning bits 127:96. They can be written only while the engine is disabled. Writes while it is enabled are ignored and set the error bit. A written-back state is used as the starting Y for the next block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the output word pointer) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| hash_key | input | 128 | Hash subkey H |
| tag_mask | input | 128 | Encrypted pre-counter block, xored into the tag |
| irq | output | 1 | Completion interrupt |

## Verification
The internal end of a multiply and a software flag-clear write can land on the same clock edge. The bench provokes this by counting edges after the fourth data word. It times a control write with the clear bit so that the write is taken on exactly the 128th edge. `irq` must be low one cycle before that edge and high just after it. This shows that the completion outranks the clear and that the latency is exactly 128 cycles.

// File: rtl/gcm_ghash_pkg.sv
package gcm_ghash_pkg;

  typedef enum logic [1:0] {
    PH_INIT    = 2'b00,
    PH_HEADER  = 2'b01,
    PH_PAYLOAD = 2'b10,
    PH_FINAL   = 2'b11
  } phase_e;

  localparam int A_CTRL  = 0;
  localparam int A_STAT  = 1;
  localparam int A_DIN   = 2;
  localparam int A_DOUT  = 3;
  localparam int A_SUSP0 = 4;

  localparam int CB_EN  = 0;
  localparam int CB_CLR = 3;
  localparam int CB_IEN = 4;

endpackage

// File: rtl/gcm_reset_sync.sv
module gcm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/gcm_word_packer.sv
module gcm_word_packer #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    push,
  input  logic [WORD_W-1:0]       word,
  output logic [WORD_W*WORDS-1:0] block_next,
  output logic                    last
);

  localparam int BW   = WORD_W * WORDS;
  localparam int CW   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int HOLD = BW - WORD_W;

  logic [HOLD-1:0] hold_q, hold_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            ce;

  assign block_next = {hold_q, word};
  assign last       = push && (cnt_q == CW'(WORDS - 1));

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (push) begin
      hold_d = block_next[HOLD-1:0];
      cnt_d  = last ? '0 : cnt_q + CW'(1);
    end
  end

  assign ce = clear || push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (ce) begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/gcm_gf_mult.sv
module gcm_gf_mult #(
  parameter int         W   = 128,
  parameter logic [W-1:0] RED = {8'hE1, {(W-8){1'b0}}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] x,
  input  logic [W-1:0] h,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int IW = $clog2(W);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  xs_q, xs_d, v_q, v_d, z_q, z_d;
  logic [W-1:0]  z_step, v_step;
  logic          last, ce;

  // one bit of X per cycle, X bit 0 (GCM order) is the vector MSB
  assign z_step = xs_q[W-1] ? (z_q ^ v_q) : z_q;
  assign v_step = v_q[0] ? ((v_q >> 1) ^ RED) : (v_q >> 1);
  assign last   = busy_q && (idx_q == IW'(W - 1));
  assign done   = last && !abort;
  assign result = z_step;
  assign busy   = busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    xs_d   = xs_q;
    v_d    = v_q;
    z_d    = z_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      xs_d   = x;
      v_d    = h;
      z_d    = '0;
    end else if (busy_q) begin
      idx_d  = idx_q + IW'(1);
      xs_d   = xs_q << 1;
      v_d    = v_step;
      z_d    = z_step;
      busy_d = !last;
    end
  end

  assign ce = abort || start || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      xs_q   <= '0;
      v_q    <= '0;
      z_q    <= '0;
    end else if (ce) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      xs_q   <= xs_d;
      v_q    <= v_d;
      z_q    <= z_d;
    end
  end

endmodule

// File: rtl/gcm_ghash_engine.sv
module gcm_ghash_engine
  import gcm_ghash_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BLOCK_W = 128,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [BLOCK_W-1:0] hash_key,
  input  logic [BLOCK_W-1:0] tag_mask,
  output logic               irq
);

  localparam int WORDS = BLOCK_W / WORD_W;
  localparam int PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic rst_sync_n;

  gcm_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // architectural state
  logic               en_q, en_d;
  phase_e             phase_q, phase_d;
  logic               ien_q, ien_d;
  logic               flag_q, flag_d;
  logic               err_q, err_d;
  logic [BLOCK_W-1:0] y_q, y_d;
  logic [PTR_W-1:0]   rptr_q, rptr_d;

  // bus decode
  logic             wr_ctrl, wr_din, wr_susp, rd_dout, is_susp;
  logic [PTR_W-1:0] sidx;
  phase_e           wr_phase;
  logic             skip, init_clear, stop_req;
  logic             din_accept, din_ignored, susp_ok, susp_ignored;

  // datapath links
  logic [BLOCK_W-1:0] pack_block;
  logic               pack_last, blk_start;
  logic               mult_busy, mult_done;
  logic [BLOCK_W-1:0] mult_result, out_blk;

  assign is_susp  = bus_addr >= ADDR_W'(A_SUSP0);
  assign sidx     = PTR_W'(bus_addr - ADDR_W'(A_SUSP0));
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_din   = bus_wr && (bus_addr == ADDR_W'(A_DIN));
  assign wr_susp  = bus_wr && is_susp;
  assign rd_dout  = bus_rd && (bus_addr == ADDR_W'(A_DOUT));
  assign wr_phase = phase_e'(bus_wdata[2:1]);

  // leaving init for payload or final needs a fresh enable write
  assign skip       = wr_ctrl && (phase_q == PH_INIT) &&
                      ((wr_phase == PH_PAYLOAD) || (wr_phase == PH_FINAL));
  assign init_clear = wr_ctrl && bus_wdata[CB_EN] && (wr_phase == PH_INIT);
  assign stop_req   = wr_ctrl && !(bus_wdata[CB_EN] && !skip);

  assign din_accept   = wr_din && en_q && (phase_q != PH_INIT) && !flag_q && !mult_busy;
  assign din_ignored  = wr_din && !din_accept;
  assign susp_ok      = wr_susp && !en_q;
  assign susp_ignored = wr_susp && en_q;
  assign blk_start    = din_accept && pack_last;

  gcm_word_packer #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear      (stop_req || init_clear),
    .push       (din_accept),
    .word       (bus_wdata),
    .block_next (pack_block),
    .last       (pack_last)
  );

  gcm_gf_mult #(.W(BLOCK_W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (blk_start),
    .abort  (stop_req),
    .x      (y_q ^ pack_block),
    .h      (hash_key),
    .busy   (mult_busy),
    .done   (mult_done),
    .result (mult_result)
  );

  always_comb begin
    en_d    = en_q;
    phase_d = phase_q;
    ien_d   = ien_q;
    flag_d  = flag_q;
    err_d   = err_q;
    y_d     = y_q;
    rptr_d  = rptr_q;
    if (wr_ctrl) begin
      phase_d = wr_phase;
      ien_d   = bus_wdata[CB_IEN];
      en_d    = bus_wdata[CB_EN] && !skip;
      if (bus_wdata[CB_CLR]) begin
        flag_d = 1'b0;
        err_d  = 1'b0;
      end
      if (init_clear) begin
        y_d    = '0;
        rptr_d = '0;
      end
    end
    if (din_ignored || susp_ignored) err_d = 1'b1;
    if (susp_ok) y_d[(WORDS - 1 - int'(sidx)) * WORD_W +: WORD_W] = bus_wdata;
    if (rd_dout) rptr_d = rptr_q + PTR_W'(1);
    if (blk_start) rptr_d = '0;
    // completion outranks a clear on the same edge
    if (mult_done) begin
      y_d    = mult_result;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      phase_q <= PH_INIT;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
      err_q   <= 1'b0;
      y_q     <= '0;
      rptr_q  <= '0;
    end else begin
      en_q    <= en_d;
      phase_q <= phase_d;
      ien_q   <= ien_d;
      flag_q  <= flag_d;
      err_q   <= err_d;
      y_q     <= y_d;
      rptr_q  <= rptr_d;
    end
  end

  assign out_blk = (phase_q == PH_FINAL) ? (y_q ^ tag_mask) : y_q;

  always_comb begin
    bus_rdata = '0;
    if (is_susp) begin
      bus_rdata = y_q[(WORDS - 1 - int'(sidx)) * WORD_W +: WORD_W];
    end else if (bus_addr == ADDR_W'(A_CTRL)) begin
      bus_rdata = WORD_W'({ien_q, 1'b0, phase_q, en_q});
    end else if (bus_addr == ADDR_W'(A_STAT)) begin
      bus_rdata = WORD_W'({mult_busy, err_q, flag_q});
    end else if (bus_addr == ADDR_W'(A_DOUT)) begin
      bus_rdata = out_blk[(WORDS - 1 - int'(rptr_q)) * WORD_W +: WORD_W];
    end
  end

  assign irq = flag_q && ien_q;

endmodule

// File: rtl/gcm_ghash_checker.sv
module gcm_ghash_checker #(
  parameter int WORD_W  = 32,
  parameter int BLOCK_W = 128,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               wdata_b2,
  input logic               en_q,
  input logic [1:0]         phase_q,
  input logic               flag_q,
  input logic               err_q,
  input logic               busy,
  input logic [BLOCK_W-1:0] y_q
);

  // R4: the flag only rises out of a running multiply
  assert_flag_from_mult_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(busy));

  // R8: a data write during a multiply is flagged as an error
  assert_busy_write_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2) && busy) |=> err_q);

  // R7: leaving init for payload or final drops the enable
  assert_skip_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && phase_q == 2'b00 && wdata_b2) |=> !en_q);

  // R9: a disabled engine never runs the multiplier
  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !busy);

  // R10: suspend writes while enabled leave the state alone
  assert_susp_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= ADDR_W'(4) && en_q && !busy) |=> $stable(y_q));

endmodule

bind gcm_ghash_engine gcm_ghash_checker #(
  .WORD_W(WORD_W), .BLOCK_W(BLOCK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wdata_b2 (bus_wdata[2]),
  .en_q     (en_q),
  .phase_q  (phase_q),
  .flag_q   (flag_q),
  .err_q    (err_q),
  .busy     (mult_busy),
  .y_q      (y_q)
);

// File: tb/tb_gcm_ghash_engine.sv
module tb_gcm_ghash_engine;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr, bus_rd;
  logic [2:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [127:0] hash_key, tag_mask;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [127:0] y_ref, got, blk, saved;
  logic [31:0]  w;

  always #2 clk = ~clk;

  gcm_ghash_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hash_key(hash_key), .tag_mask(tag_mask), .irq(irq)
  );

  function automatic logic [127:0] gfmul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z = '0;
    logic [127:0] v = b;
    for (int i = 0; i < 128; i++) begin
      if (a[127 - i]) z = z ^ v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'b0}) : (v >> 1);
    end
    return z;
  endfunction

  function automatic logic [31:0] cw(input bit en, input logic [1:0] ph, input bit clr, input bit ien);
    return {27'b0, ien, clr, ph, en};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic feed(input logic [127:0] b);
    for (int k = 0; k < 4; k++) wr(3'd2, b[127 - 32*k -: 32]);
  endtask

  task automatic read_out(output logic [127:0] b);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(3'd3, d);
      b[127 - 32*k -: 32] = d;
    end
  endtask

  task automatic read_susp(output logic [127:0] b);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), d);
      b[127 - 32*k -: 32] = d;
    end
  endtask

  task automatic wait_flag();
    logic [31:0] d;
    d = '0;
    for (int n = 0; n < 300 && !d[0]; n++) rd(3'd1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    hash_key = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    tag_mask = 128'h58e2fccefa7e3061367f1d57a4e7455a;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    check("R1 irq", {127'b0, irq}, '0);
    rd(3'd0, w); check("R1 ctrl", {96'b0, w}, '0);
    rd(3'd1, w); check("R1 status", {96'b0, w}, '0);
    read_susp(got); check("R1 susp", got, '0);

    // R5 init, then header; chained sweep (R2 R3 R4)
    wr(3'd0, cw(1, 2'b00, 0, 1));
    wr(3'd0, cw(1, 2'b01, 0, 1));
    y_ref = '0;
    for (int i = 0; i < 10; i++) begin
      hash_key = {32'h9E3779B9 * (i + 1), 32'h7F4A7C15 ^ i, ~(32'h1 << i), 32'h0BADF00D + i};
      blk = {32'h01000193 * (i + 3), 32'h1 << (3 * i), 32'hA5A5A5A5 ^ i, 32'(i * i)};
      feed(blk);
      wait_flag();
      y_ref = gfmul(y_ref ^ blk, hash_key);
      check("R4 irq with enable", {127'b0, irq}, 128'd1);
      read_out(got);
      check("R2 R3 chained header block", got, y_ref);
      wr(3'd0, cw(1, 2'b01, 1, 1));
      check("R4 irq after clear", {127'b0, irq}, '0);
    end

    // R2 identity subkey: result equals Y xor X
    hash_key = {1'b1, 127'b0};
    blk = 128'h0123456789abcdef_fedcba9876543210;
    feed(blk); wait_flag();
    y_ref = y_ref ^ blk;
    read_out(got); check("R2 identity multiply", got, y_ref);
    wr(3'd0, cw(1, 2'b01, 1, 0));

    // R6 header -> final without disabling, tag = GHASH xor mask
    hash_key = 128'hb83b533708bf535d0aa6e52980d53b78;
    wr(3'd0, cw(1, 2'b11, 0, 0));
    blk = {64'd1408, 64'd0};
    feed(blk); wait_flag();
    y_ref = gfmul(y_ref ^ blk, hash_key);
    read_out(got); check("R6 tag output", got, y_ref ^ tag_mask);
    rd(3'd1, w); check("R6 no error header to final", {127'b0, w[1]}, '0);
    check("R4 irq masked", {127'b0, irq}, '0);
    wr(3'd0, cw(1, 2'b11, 1, 0));

    // R5 init clears state
    wr(3'd0, cw(1, 2'b00, 0, 0));
    read_susp(got); check("R5 init clears Y", got, '0);
    y_ref = '0;

    // R7 skip init -> payload
    wr(3'd0, cw(1, 2'b10, 0, 0));
    rd(3'd0, w); check("R7 enable dropped on skip", {125'b0, w[2:0]}, {125'b0, 3'b100});
    wr(3'd2, 32'hDEADBEEF);
    rd(3'd1, w); check("R8 write while disabled errs", {127'b0, w[1]}, 128'd1);
    wr(3'd0, cw(1, 2'b10, 1, 0));
    rd(3'd0, w); check("R7 re-enable works", {127'b0, w[0]}, 128'd1);
    blk = 128'h00112233445566778899aabbccddeeff;
    feed(blk);
    wr(3'd2, 32'h55555555);
    rd(3'd1, w); check("R8 write while busy errs", {125'b0, w[2:0]}, {125'b0, 3'b110});
    wait_flag();
    y_ref = gfmul(y_ref ^ blk, hash_key);
    read_out(got); check("R8 busy write had no effect", got, y_ref);
    wr(3'd2, 32'h66666666);
    wr(3'd0, cw(1, 2'b10, 1, 0));
    blk = 128'hffeeddccbbaa99887766554433221100;
    feed(blk); wait_flag();
    y_ref = gfmul(y_ref ^ blk, hash_key);
    read_out(got); check("R8 write while flagged ignored", got, y_ref);
    wr(3'd0, cw(1, 2'b10, 1, 0));

    // R9 abort mid-multiply, and partial block discard
    feed(128'h1);
    repeat (20) @(negedge clk);
    wr(3'd0, cw(0, 2'b10, 0, 0));
    rd(3'd1, w); check("R9 abort idle and no flag", {125'b0, w[2:0]}, '0);
    read_susp(got); check("R9 Y unchanged by abort", got, y_ref);
    wr(3'd0, cw(1, 2'b10, 0, 0));
    wr(3'd2, 32'h12345678); wr(3'd2, 32'h9abcdef0);
    wr(3'd0, cw(0, 2'b10, 0, 0));
    wr(3'd0, cw(1, 2'b10, 0, 0));
    blk = 128'h0f0e0d0c0b0a09080706050403020100;
    feed(blk); wait_flag();
    y_ref = gfmul(y_ref ^ blk, hash_key);
    read_out(got); check("R9 partial block discarded", got, y_ref);
    wr(3'd0, cw(1, 2'b01, 1, 0));

    // R10 suspend read, locked write, restore
    read_susp(got); check("R10 suspend read", got, y_ref);
    wr(3'd4, 32'h0);
    rd(3'd1, w); check("R10 locked write errs", {127'b0, w[1]}, 128'd1);
    read_susp(got); check("R10 locked write ignored", got, y_ref);
    wr(3'd0, cw(0, 2'b01, 1, 0));
    saved = 128'hcafebabe_11223344_55667788_99aabbcc;
    for (int k = 0; k < 4; k++) wr(3'(4 + k), saved[127 - 32*k -: 32]);
    read_susp(got); check("R10 restore readback", got, saved);
    wr(3'd0, cw(1, 2'b01, 0, 0));
    blk = 128'h3c3c3c3c_c3c3c3c3_5a5a5a5a_a5a5a5a5;
    feed(blk); wait_flag();
    y_ref = gfmul(saved ^ blk, hash_key);
    read_out(got); check("R10 resume from restored Y", got, y_ref);
    wr(3'd0, cw(1, 2'b01, 1, 1));

    // R2 R4 clear coinciding with completion on edge 128
    blk = 128'h8badf00d_00000001_deadc0de_80000000;
    feed(blk);
    repeat (127) @(negedge clk);
    check("R2 flag not yet set at edge 127", {127'b0, irq}, '0);
    wr(3'd0, cw(1, 2'b01, 1, 1));
    check("R4 completion beats clear", {127'b0, irq}, 128'd1);
    y_ref = gfmul(y_ref ^ blk, hash_key);
    read_out(got); check("R3 result after coincidence", got, y_ref);
    wr(3'd0, cw(1, 2'b01, 1, 1));
    check("R4 later clear works", {127'b0, irq}, '0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule